// File: doc/BRIEF.md
# Multi-Island Queue-Feedback Frequency Controller

This block sets the clock level of every voltage-frequency island in a design whose islands trade data through mixed-clock FIFOs. It watches the occupancy of each interface queue once per cycle. Over a fixed control window of 2^LOG_INT cycles it reduces those samples to an average utilization per queue. At the close of each window it forms the error between a programmed target utilization and that average. A programmed gain matrix, which couples every queue to every island, multiplies the error vector. Each island's product is rounded to an integer frequency command, clamped to the span of the clock table, and snapped to the nearest available level.

The gain matrix enters through a port and is sampled only at the close of a window. Software can therefore swap between gain sets computed off-line while the loop runs. An island can be held at a fixed level through a pin mask, which serves the pipeline case where one stage's clock is set by a throughput target and the others follow the loop. Frequencies are expressed in units of F_MIN/… table steps. With the default parameters the unit is 0.625 MHz, and the four levels 20, 24, 28 and 32 stand for 12.5, 15, 17.5 and 20 MHz. A valid configuration regulates no more queues than there are islands (NQ ≤ NI).

Top module: `vfi_freq_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) puts every island's level output at NLVL-1, the highest level, and holds upd_o low.
- R2: Level outputs change only on the edge that closes a window of 2^LOG_INT cycles counted from reset release. upd_o is high for exactly the one cycle that follows each such edge.
- R3: Queue j's utilization is floor(sum of its occupancy over the window's 2^LOG_INT cycles / 2^LOG_INT). The occupancy is unsigned OW bits at occ_i[j*OW +: OW].
- R4: Island i's command is floor((sum over j of K[i][j]*(ref[j]-util[j]) + 2^(FRAC-1)) / 2^FRAC). K is signed two's-complement GW bits with FRAC fractional bits, and the products are summed at full width before rounding.
- R5: The command is clamped to [F_MIN, F_MIN+(NLVL-1)*F_STEP] before quantization, so a command below the table gives level 0 and one above gives NLVL-1.
- R6: The level code is the binary index l of frequency F_MIN+l*F_STEP, with 0 the slowest. The chosen l is the table entry nearest the clamped command, and an exact midpoint takes the higher level.
- R7: An island whose pin_mask_i bit is set at the window close takes pin_level_i instead of its computed level.
- R8: gain_i, ref_i and pin inputs are used only at the window-closing edge. A gain set swapped in mid-window governs the update at the end of that window.
- R9: K[i][j] sits at gain_i[(i*NQ+j)*GW +: GW], ref[j] at ref_i[j*OW +: OW] (unsigned), and island i's level at lvl_o[i*LW +: LW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| occ_i | input | NQ*OW | Per-queue FIFO occupancy, sampled each cycle |
| ref_i | input | NQ*OW | Target utilization per queue |
| gain_i | input | NI*NQ*GW | Signed fixed-point gain matrix, row per island |
| pin_mask_i | input | NI | Islands held at the pinned level |
| pin_level_i | input | LW | Level applied to pinned islands |
| lvl_o | output | NI*LW | Current clock level per island |
| upd_o | output | 1 | One-cycle strobe after each new level vector |

## Verification
A behavioural model is compared against the block on every cycle while occupancy varies randomly, which separates averaging errors from errors in the gain product. Directed patterns drive the commands far above and below the table to expose missing clamps. They also place commands exactly on and one unit below a midpoint between levels, which tells ties-up rounding from ties-down or truncation. A mid-window gain swap and a pinned island show whether inputs are sampled at the right edge and whether the pin overrides the feedback law.

// File: rtl/vfi_ctrl_pkg.sv
package vfi_ctrl_pkg;
  // round half up: floor((acc + 2^(frac-1)) / 2^frac)
  function automatic int round_frac(input int acc, input int frac);
    int biased;
    biased = acc + (1 <<< (frac - 1));
    return biased >>> frac;
  endfunction

  function automatic int clamp(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/vfi_util_avg.sv
module vfi_util_avg #(
  parameter int NQ      = 2,
  parameter int OW      = 5,
  parameter int LOG_INT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NQ*OW-1:0] occ_i,
  output logic [NQ*OW-1:0] util_o,
  output logic             win_o
);
  localparam int SW = OW + LOG_INT;

  logic [LOG_INT-1:0] cnt_q;
  logic [SW-1:0]      sum_q   [NQ];
  logic [SW-1:0]      sum_nxt [NQ];

  assign win_o = (cnt_q == {LOG_INT{1'b1}});

  for (genvar j = 0; j < NQ; j++) begin : g_q
    assign sum_nxt[j] = sum_q[j] + SW'(occ_i[j*OW +: OW]);
    assign util_o[j*OW +: OW] = sum_nxt[j][SW-1:LOG_INT];

    always_ff @(posedge clk) begin
      if (rst || win_o) sum_q[j] <= '0;
      else              sum_q[j] <= sum_nxt[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/vfi_island_law.sv
module vfi_island_law
  import vfi_ctrl_pkg::*;
#(
  parameter int NQ     = 2,
  parameter int OW     = 5,
  parameter int GW     = 8,
  parameter int FRAC   = 4,
  parameter int F_MIN  = 20,
  parameter int F_STEP = 4,
  parameter int NLVL   = 4,
  parameter int LW     = 2
) (
  input  logic [NQ*OW-1:0] util_i,
  input  logic [NQ*OW-1:0] ref_i,
  input  logic [NQ*GW-1:0] gain_row_i,
  output logic [LW-1:0]    lvl_o
);
  localparam int F_MAX = F_MIN + (NLVL - 1) * F_STEP;

  // nearest table entry; a midpoint counts toward the upper level
  function automatic logic [LW-1:0] pick_level(input int cmd);
    int n;
    n = 0;
    for (int l = 1; l < NLVL; l++)
      if (2 * cmd >= 2 * F_MIN + (2 * l - 1) * F_STEP) n++;
    return LW'(n);
  endfunction

  int acc;
  int cmd;

  always_comb begin
    acc = 0;
    for (int j = 0; j < NQ; j++)
      acc += int'($signed(gain_row_i[j*GW +: GW])) *
             (int'(ref_i[j*OW +: OW]) - int'(util_i[j*OW +: OW]));
    cmd   = clamp(round_frac(acc, FRAC), F_MIN, F_MAX);
    lvl_o = pick_level(cmd);
  end
endmodule

// File: rtl/vfi_freq_ctrl.sv
module vfi_freq_ctrl #(
  parameter int NQ      = 2,
  parameter int NI      = 3,
  parameter int OW      = 5,
  parameter int GW      = 8,
  parameter int FRAC    = 4,
  parameter int LOG_INT = 3,
  parameter int F_MIN   = 20,
  parameter int F_STEP  = 4,
  parameter int NLVL    = 4,
  parameter int LW      = $clog2(NLVL)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NQ*OW-1:0]    occ_i,
  input  logic [NQ*OW-1:0]    ref_i,
  input  logic [NI*NQ*GW-1:0] gain_i,
  input  logic [NI-1:0]       pin_mask_i,
  input  logic [LW-1:0]       pin_level_i,
  output logic [NI*LW-1:0]    lvl_o,
  output logic                upd_o
);
  localparam logic [LW-1:0] TOP_LVL = LW'(NLVL - 1);

  logic [NQ*OW-1:0] util;
  logic             win_done;
  logic [LW-1:0]    law_lvl [NI];
  logic [NI*LW-1:0] lvl_q;
  logic             upd_q;

  vfi_util_avg #(.NQ(NQ), .OW(OW), .LOG_INT(LOG_INT)) u_avg (
    .clk(clk), .rst(rst), .occ_i(occ_i), .util_o(util), .win_o(win_done)
  );

  for (genvar i = 0; i < NI; i++) begin : g_isl
    vfi_island_law #(
      .NQ(NQ), .OW(OW), .GW(GW), .FRAC(FRAC),
      .F_MIN(F_MIN), .F_STEP(F_STEP), .NLVL(NLVL), .LW(LW)
    ) u_law (
      .util_i(util), .ref_i(ref_i),
      .gain_row_i(gain_i[i*NQ*GW +: NQ*GW]),
      .lvl_o(law_lvl[i])
    );

    always_ff @(posedge clk) begin
      if (rst)
        lvl_q[i*LW +: LW] <= TOP_LVL;
      else if (win_done)
        lvl_q[i*LW +: LW] <= pin_mask_i[i] ? pin_level_i : law_lvl[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) upd_q <= 1'b0;
    else     upd_q <= win_done;
  end

  assign lvl_o = lvl_q;
  assign upd_o = upd_q;
endmodule

// File: rtl/vfi_freq_ctrl_chk.sv
module vfi_freq_ctrl_chk #(
  parameter int NI   = 3,
  parameter int NLVL = 4,
  parameter int LW   = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [NI-1:0]    pin_mask_i,
  input logic [LW-1:0]    pin_level_i,
  input logic [NI*LW-1:0] lvl_o,
  input logic             upd_o,
  input logic             win_done
);
  localparam logic [NI*LW-1:0] ALL_TOP = {NI{LW'(NLVL - 1)}};

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!upd_o && lvl_o == ALL_TOP));

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    upd_o |=> !upd_o);

  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (rst)
    win_done |=> upd_o);

  assert_hold_between_R2: assert property (@(posedge clk) disable iff (rst)
    !win_done |=> $stable(lvl_o));

  for (genvar i = 0; i < NI; i++) begin : g_pin
    assert_pinned_level_R7: assert property (@(posedge clk) disable iff (rst)
      (win_done && pin_mask_i[i]) |=> (lvl_o[i*LW +: LW] == $past(pin_level_i)));
  end
endmodule

bind vfi_freq_ctrl vfi_freq_ctrl_chk #(.NI(NI), .NLVL(NLVL), .LW(LW)) u_chk (.*);

// File: tb/test_vfi_freq_ctrl.sv
module test_vfi_freq_ctrl;
  localparam int NQ = 2, NI = 3, OW = 5, GW = 8, FRAC = 4, LOG_INT = 3;
  localparam int F_MIN = 20, F_STEP = 4, NLVL = 4, LW = 2;
  localparam int WIN = 1 << LOG_INT;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [NQ*OW-1:0]    occ_i;
  logic [NQ*OW-1:0]    ref_i;
  logic [NI*NQ*GW-1:0] gain_i;
  logic [NI-1:0]       pin_mask_i = '0;
  logic [LW-1:0]       pin_level_i = '0;
  logic [NI*LW-1:0]    lvl_o;
  logic                upd_o;

  int occ  [NQ];
  int refv [NQ];
  logic signed [GW-1:0] kmat [NI][NQ];

  always_comb begin
    for (int j = 0; j < NQ; j++) begin
      occ_i[j*OW +: OW] = OW'(occ[j]);
      ref_i[j*OW +: OW] = OW'(refv[j]);
    end
    for (int i = 0; i < NI; i++)
      for (int j = 0; j < NQ; j++)
        gain_i[(i*NQ+j)*GW +: GW] = kmat[i][j];   // R9 layout
  end

  vfi_freq_ctrl i_vfi_freq_ctrl (
    .clk(clk), .rst(rst), .occ_i(occ_i), .ref_i(ref_i), .gain_i(gain_i),
    .pin_mask_i(pin_mask_i), .pin_level_i(pin_level_i),
    .lvl_o(lvl_o), .upd_o(upd_o)
  );

  always #2.5 clk = ~clk;

  int    vectors = 0;
  int    fails   = 0;
  bit    done    = 0;
  string tag     = "R1";
  bit    rnd_occ = 0;

  // behavioural reference state
  int m_cnt = 0;
  int m_sum [NQ];
  int m_lvl [NI];
  bit m_upd = 0;

  function automatic int nearest(input int cmd);
    int best = 0, bd = 1 << 30;
    for (int l = 0; l < NLVL; l++) begin
      int f = F_MIN + l * F_STEP;
      int d = (cmd > f) ? cmd - f : f - cmd;
      if (d <= bd) begin bd = d; best = l; end
    end
    return best;
  endfunction

  task automatic model_step();
    if (rst) begin
      m_cnt = 0; m_upd = 0;
      for (int j = 0; j < NQ; j++) m_sum[j] = 0;
      for (int i = 0; i < NI; i++) m_lvl[i] = NLVL - 1;
    end else begin
      for (int j = 0; j < NQ; j++) m_sum[j] += occ[j];
      if (m_cnt == WIN - 1) begin
        for (int i = 0; i < NI; i++) begin
          int acc = 0, cmd;
          for (int j = 0; j < NQ; j++)
            acc += int'(kmat[i][j]) * (refv[j] - m_sum[j] / WIN);
          cmd = (acc + (1 << (FRAC - 1))) >>> FRAC;
          if (cmd < F_MIN) cmd = F_MIN;
          if (cmd > F_MIN + (NLVL - 1) * F_STEP) cmd = F_MIN + (NLVL - 1) * F_STEP;
          m_lvl[i] = pin_mask_i[i] ? int'(pin_level_i) : nearest(cmd);
        end
        m_upd = 1; m_cnt = 0;
        for (int j = 0; j < NQ; j++) m_sum[j] = 0;
      end else begin
        m_upd = 0; m_cnt++;
      end
    end
  endtask

  task automatic compare();
    for (int i = 0; i < NI; i++) begin
      vectors++;
      if (int'(lvl_o[i*LW +: LW]) != m_lvl[i]) begin
        fails++;
        $display("FAIL %s (R3 R4 R5 R6) island %0d level actual %0d expected %0d",
                 tag, i, lvl_o[i*LW +: LW], m_lvl[i]);
      end
    end
    vectors++;
    if (upd_o != m_upd) begin
      fails++;
      $display("FAIL %s R2 strobe actual %0d expected %0d", tag, upd_o, m_upd);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    if (rnd_occ)
      for (int j = 0; j < NQ; j++) occ[j] = int'($urandom_range(0, 31));
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic clear_gains();
    for (int i = 0; i < NI; i++)
      for (int j = 0; j < NQ; j++) kmat[i][j] = '0;
  endtask

  initial begin
    for (int j = 0; j < NQ; j++) begin occ[j] = 0; refv[j] = 0; end
    clear_gains();
    // R1: reset state
    tag = "R1";
    run(2);
    rst = 1'b0;
    // R3 R4: coupled gains, random occupancy
    tag = "R3 R4 random";
    rnd_occ = 1;
    refv[0] = 20; refv[1] = 12;
    kmat[0][0] = 8'sd16; kmat[0][1] = -8'sd4;
    kmat[1][0] = 8'sd6;  kmat[1][1] = 8'sd24;
    kmat[2][0] = 8'sd40; kmat[2][1] = 8'sd3;
    run(10 * WIN);
    // R5: drive commands past both ends of the table
    tag = "R5 high";
    rnd_occ = 0; occ[0] = 0; occ[1] = 0; refv[0] = 31; refv[1] = 31;
    for (int i = 0; i < NI; i++) begin kmat[i][0] = 8'sd127; kmat[i][1] = 8'sd127; end
    run(2 * WIN);
    tag = "R5 low";
    for (int i = 0; i < NI; i++) begin kmat[i][0] = -8'sd128; kmat[i][1] = -8'sd128; end
    run(2 * WIN);
    // R6: midpoint ties and just-below-midpoint
    tag = "R6 tie";
    clear_gains();
    kmat[0][0] = 8'sd16; kmat[1][1] = 8'sd16; kmat[2][0] = 8'sd16;
    refv[0] = 22; refv[1] = 26; occ[0] = 0; occ[1] = 0;
    run(2 * WIN);
    tag = "R6 below";
    refv[0] = 21; refv[1] = 29;
    run(2 * WIN);
    // R4: half-unit rounding with utilization subtraction
    tag = "R4 round";
    kmat[0][0] = 8'sd24; refv[0] = 31; occ[0] = 16; // 1.5*15 = 22.5 -> 23
    run(2 * WIN);
    // R7: pinned island
    tag = "R7 pin";
    rnd_occ = 1;
    pin_mask_i = 3'b010; pin_level_i = 2'd3;
    run(3 * WIN);
    pin_mask_i = 3'b101; pin_level_i = 2'd0;
    run(3 * WIN);
    pin_mask_i = '0;
    // R8: swap gain set in the middle of a window
    tag = "R8 swap";
    run(3);
    kmat[0][0] = -8'sd20; kmat[0][1] = 8'sd50;
    kmat[1][0] = 8'sd33;  kmat[1][1] = -8'sd7;
    run(WIN);
    kmat[2][0] = 8'sd9; kmat[2][1] = 8'sd60;
    run(3 * WIN);
    // R2 R9: long random run across many windows
    tag = "R2 R9 long";
    run(20 * WIN);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired during %s", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule